// File: doc/BRIEF.md
# Shared-Pin General-Purpose I/O Port

This block is one 8-bit general-purpose I/O port. Software reaches it through a small register bus with four byte-wide registers: output data, pullup enable, slew enable and direction. The block turns those registers into per-pin pad controls for the pad ring: output enable, output value, pullup enable and slew enable. A read of the data register returns the output latch for pins driven by the port. For all other pins it returns the pin level after a two-flop synchronizer.

Some pins can be taken by other functions. Pin 0 belongs to a debug/mode function while reset is asserted. After reset it stays with that function for as long as `dbg_claim` is high. Pins 1 and 2 belong to the oscillator or external-clock function while `osc_claim` is high. While another function owns a pin, the port drives nothing on that pin's pad controls. Its register bits are kept but have no effect, and a data read of that pin returns the synchronized pin level.

Top module: `gpio_share_port`

## Requirements
- R1: After a reset, all four registers hold 0. Every pad control output is then 0, and a read of the pullup, slew or direction register returns 0.
- R2: Register select `bus_addr` is decoded as 0 = data, 1 = pullup enable, 2 = slew enable, 3 = direction. A write takes effect on the clock edge where `bus_we` is high. Reads are combinational, and a read of addresses 1 to 3 returns the stored byte whatever the ownership state.
- R3: For a port-owned pin whose direction bit is 1, the block sets `pad_oe` to 1 and drives `pad_out` with the data latch bit. A data read returns that latch bit.
- R4: For a port-owned pin whose direction bit is 0, `pad_oe` and `pad_out` are 0. A data read returns the pin level, which passes through two flops and so appears two clock edges after `pin_in` changes.
- R5: `pad_pu` follows the pullup bit (1 = enabled) only on port-owned input pins. It is 0 on output pins.
- R6: `pad_slew` follows the slew bit (1 = enabled) only on port-owned output pins. It is 0 on input pins.
- R7: While `rst_n` is low, pin 0 is owned by the debug function with no clock edge needed. `pad_oe[0]`, `pad_out[0]`, `pad_pu[0]` and `pad_slew[0]` are then 0.
- R8: After reset, while `dbg_claim` is high, pin 0 stays owned. All four pad controls of pin 0 are 0, and a data read of bit 0 returns the synchronized pin level.
- R9: While `osc_claim` is high, pins 1 and 2 are owned by the oscillator function. Their data, direction, pullup and slew bits have no effect and their pad controls are 0.
- R10: A write to the data register updates the latch even for input or owned pins. The stored value drives the pin as soon as the pin is port-owned with its direction bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also gives pin 0 to the debug function |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Levels seen at the pads |
| dbg_claim | input | 1 | Debug/mode function keeps pin 0 |
| osc_claim | input | 1 | Oscillator function takes pins 1 and 2 |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pullup enable |
| pad_slew | output | 8 | Per-pin slew-rate control enable |

## Verification
The assertions assume that `osc_claim` and `dbg_claim` are synchronous to `clk` and stay stable across a write to the direction register. Under that assumption, the pins that are never shared show the written direction on the next cycle. The stimulus changes the claim inputs only together with, or between, register writes and holds them through each settling window. It also leaves two clock edges after any `pin_in` change before it reads the data register, so the synchronizer delay is never observed mid-flight.

// File: rtl/gpio_share_pkg.sv
// Package: register select encoding shared by the port RTL.
// Assumes a 2-bit register select on the bus.
package gpio_share_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_PULL = 2'd1,
        SEL_SLEW = 2'd2,
        SEL_DIR  = 2'd3
    } reg_sel_e;

    localparam int unsigned NUM_REGS = 4;
endpackage

// File: rtl/gpio_share_regs.sv
// Register bank: four WIDTH-bit control registers written by a single-cycle
// strobe. Assumes a synchronous active-low reset that clears every register.
module gpio_share_regs
    import gpio_share_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] pull_q,
    output logic [WIDTH-1:0] slew_q,
    output logic [WIDTH-1:0] dir_q
);
    logic [WIDTH-1:0] bank_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam logic [1:0] MY_SEL = 2'(r);
        // Load one register when its select matches a write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[r] <= '0;
            else if (wr_en && (wr_sel == MY_SEL))
                bank_q[r] <= wr_data;
        end
    end

    // Present the bank under named outputs.
    always_comb begin
        data_q = bank_q[SEL_DATA];
        pull_q = bank_q[SEL_PULL];
        slew_q = bank_q[SEL_SLEW];
        dir_q  = bank_q[SEL_DIR];
    end
endmodule

// File: rtl/gpio_share_sync.sv
// Input synchronizer: STAGES flops per bit between the pads and read data.
// Assumes pin levels are asynchronous to clk; reset clears the chain.
module gpio_share_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    // First stage captures the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q[0] <= '0;
        else
            chain_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage copies the stage before it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain_q[s] <= '0;
            else
                chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/gpio_share_pinctl.sv
// Per-pin control: turns the pin's register bits and ownership flag into
// pad controls and the pin's read-data bit. Purely combinational; assumes
// an owned pin is driven entirely by the function that claims it.
module gpio_share_pinctl (
    input  logic own,
    input  logic dir,
    input  logic data,
    input  logic pull,
    input  logic slew,
    input  logic pin_sync,
    output logic oe,
    output logic out,
    output logic pu,
    output logic sl,
    output logic rd
);
    logic drive;
    logic listen;

    // Decide whether the port drives the pin or only listens to it.
    always_comb begin
        drive  = !own && dir;
        listen = !own && !dir;
    end

    // Gate every register bit by the pin's mode.
    always_comb begin
        oe  = drive;
        out = drive && data;
        pu  = listen && pull;
        sl  = drive && slew;
        rd  = drive ? data : pin_sync;
    end
endmodule

// File: rtl/gpio_share_port.sv
// Shared-pin GPIO port top: register bank, input synchronizer, ownership
// masks and one pin controller per bit. Assumes claim inputs are synchronous
// to clk; pin DBG_PIN is owned by the debug function whenever rst_n is low.
module gpio_share_port
    import gpio_share_pkg::*;
#(
    parameter int unsigned     WIDTH    = 8,
    parameter int unsigned     DBG_PIN  = 0,
    parameter logic [WIDTH-1:0] OSC_MASK = 8'b0000_0110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             dbg_claim,
    input  logic             osc_claim,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu,
    output logic [WIDTH-1:0] pad_slew
);
    localparam logic [WIDTH-1:0] DBG_MASK = WIDTH'(1) << DBG_PIN;
    localparam int unsigned      SYNC_STAGES = 2;

    logic [WIDTH-1:0] data_q, pull_q, slew_q, dir_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] own_mask;
    logic [WIDTH-1:0] rd_data_bits;

    gpio_share_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_sel  (bus_addr),
        .wr_data (bus_wdata),
        .data_q  (data_q),
        .pull_q  (pull_q),
        .slew_q  (slew_q),
        .dir_q   (dir_q)
    );

    gpio_share_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    // Build the set of pins currently held by another function.
    always_comb begin
        own_mask = '0;
        if (osc_claim)
            own_mask = own_mask | OSC_MASK;
        if (dbg_claim || !rst_n)
            own_mask = own_mask | DBG_MASK;
    end

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        gpio_share_pinctl u_pin (
            .own      (own_mask[p]),
            .dir      (dir_q[p]),
            .data     (data_q[p]),
            .pull     (pull_q[p]),
            .slew     (slew_q[p]),
            .pin_sync (pin_sync[p]),
            .oe       (pad_oe[p]),
            .out      (pad_out[p]),
            .pu       (pad_pu[p]),
            .sl       (pad_slew[p]),
            .rd       (rd_data_bits[p])
        );
    end

    // Select read data by register.
    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_DATA: bus_rdata = rd_data_bits;
            SEL_PULL: bus_rdata = pull_q;
            SEL_SLEW: bus_rdata = slew_q;
            SEL_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_share_port_chk.sv
// Checker for gpio_share_port: port-level properties of pad controls and
// ownership. Attached to every instance of the top by the bind below.
module gpio_share_port_chk #(
    parameter int unsigned      WIDTH    = 8,
    parameter int unsigned      DBG_PIN  = 0,
    parameter logic [WIDTH-1:0] OSC_MASK = 8'b0000_0110
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic             dbg_claim,
    input logic             osc_claim,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_pu,
    input logic [WIDTH-1:0] pad_slew
);
    localparam logic [WIDTH-1:0] DBG_MASK  = WIDTH'(1) << DBG_PIN;
    localparam logic [WIDTH-1:0] FREE_MASK = ~(OSC_MASK | DBG_MASK);

    // R5: pullup never active on a driven pin.
    a_r5_pu_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R6: slew control never active on an undriven pin.
    a_r6_slew_outputs_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_slew & ~pad_oe) == '0);

    // R3: a direction write on unshared pins shows on pad_oe next cycle.
    a_r3_dir_write_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3) |=> ((pad_oe & FREE_MASK) == ($past(bus_wdata) & FREE_MASK)));

    // R9: oscillator-owned pins carry no port pad controls.
    a_r9_osc_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
        osc_claim |-> (((pad_oe | pad_out | pad_pu | pad_slew) & OSC_MASK) == '0));

    // R8: debug-owned pin 0 carries no port pad controls after reset.
    a_r8_dbg_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_claim |-> (((pad_oe | pad_out | pad_pu | pad_slew) & DBG_MASK) == '0));

    // R7: during reset the debug pin is released by the port.
    always @(posedge clk) begin
        if (!rst_n)
            a_r7_reset_owns_dbg_pin: assert (((pad_oe | pad_out | pad_pu | pad_slew) & DBG_MASK) == '0);
    end
endmodule

bind gpio_share_port gpio_share_port_chk #(
    .WIDTH    (WIDTH),
    .DBG_PIN  (DBG_PIN),
    .OSC_MASK (OSC_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .dbg_claim (dbg_claim),
    .osc_claim (osc_claim),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .pad_slew  (pad_slew)
);

// File: tb/gpio_share_port_test.sv
// Bench for gpio_share_port: a vector table walked in order, then directed
// checks of reset state and reset-time ownership of pin 0.
module gpio_share_port_test;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic       we;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [7:0] pin;
        logic       osc;
        logic       dbg;
        logic [1:0] raddr;
        logic [7:0] rd;
        logic [7:0] oe;
        logic [7:0] out;
        logic [7:0] pu;
        logic [7:0] sl;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        // R3 R4: upper nibble outputs, lower nibble reads pins
        '{1'b1, 2'd3, 8'hF0, 8'hAA, 1'b0, 1'b0, 2'd0, 8'h0A, 8'hF0, 8'h00, 8'h00, 8'h00},
        // R3: latch drives outputs, read mixes latch and pins
        '{1'b1, 2'd0, 8'h5C, 8'hAA, 1'b0, 1'b0, 2'd0, 8'h5A, 8'hF0, 8'h50, 8'h00, 8'h00},
        // R5 R2: pullups only on inputs, readback of pullup register
        '{1'b1, 2'd1, 8'hFF, 8'h33, 1'b0, 1'b0, 2'd1, 8'hFF, 8'hF0, 8'h50, 8'h0F, 8'h00},
        // R6 R2: slew only on outputs, readback of slew register
        '{1'b1, 2'd2, 8'h3C, 8'h33, 1'b0, 1'b0, 2'd2, 8'h3C, 8'hF0, 8'h50, 8'h0F, 8'h30},
        // R9: oscillator takes pins 1,2 (input pullups masked)
        '{1'b0, 2'd0, 8'h00, 8'h33, 1'b1, 1'b0, 2'd0, 8'h53, 8'hF0, 8'h50, 8'h09, 8'h30},
        // R9 R2: all outputs, pins 1,2 still owned; direction readback
        '{1'b1, 2'd3, 8'hFF, 8'h00, 1'b1, 1'b0, 2'd3, 8'hFF, 8'hF9, 8'h58, 8'h00, 8'h38},
        // R8 R10: debug keeps pin 0, data written while owned
        '{1'b1, 2'd0, 8'hFF, 8'h00, 1'b1, 1'b1, 2'd0, 8'hF8, 8'hF8, 8'hF8, 8'h00, 8'h38},
        // R10: claims released, stored data appears
        '{1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h3C},
        // R4 R5: all inputs, pins read, pullups on
        '{1'b1, 2'd3, 8'h00, 8'h96, 1'b0, 1'b0, 2'd0, 8'h96, 8'h00, 8'h00, 8'hFF, 8'h00},
        // R8: debug masks pin 0 pullup
        '{1'b0, 2'd0, 8'h00, 8'h96, 1'b0, 1'b1, 2'd0, 8'h96, 8'h00, 8'h00, 8'hFE, 8'h00},
        // R10 R4: data write to input pins not visible on read
        '{1'b1, 2'd0, 8'hA5, 8'h0F, 1'b0, 1'b1, 2'd0, 8'h0F, 8'h00, 8'h00, 8'hFE, 8'h00},
        // R10 R3: stored data drives once pins become outputs
        '{1'b1, 2'd3, 8'h0F, 8'hF0, 1'b0, 1'b0, 2'd0, 8'hF5, 8'h0F, 8'h05, 8'hF0, 8'h0C}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic       dbg_claim = 1'b0;
    logic       osc_claim = 1'b0;
    logic [7:0] pad_oe, pad_out, pad_pu, pad_slew;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    gpio_share_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .dbg_claim (dbg_claim),
        .osc_claim (osc_claim),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu),
        .pad_slew  (pad_slew)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) settle();
        rst_n = 1'b1;
        settle();
        settle();
        check("R1", "pad_oe", pad_oe, 8'h00);
        check("R1", "pad_out", pad_out, 8'h00);
        check("R1", "pad_pu", pad_pu, 8'h00);
        check("R1", "pad_slew", pad_slew, 8'h00);
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1;
            check("R1", "rdata", bus_rdata, 8'h00);
        end

        // Vector table walk: R2..R10
        for (int i = 0; i < NVEC; i++) begin
            bus_we    = VECS[i].we;
            bus_addr  = VECS[i].addr;
            bus_wdata = VECS[i].wdata;
            pin_in    = VECS[i].pin;
            osc_claim = VECS[i].osc;
            dbg_claim = VECS[i].dbg;
            settle();
            bus_we = 1'b0;
            settle();
            settle();
            bus_addr = VECS[i].raddr;
            #1;
            check("R2-R10 vec", "rdata", bus_rdata, VECS[i].rd);
            check("R3 vec", "pad_oe", pad_oe, VECS[i].oe);
            check("R10 vec", "pad_out", pad_out, VECS[i].out);
            check("R5 vec", "pad_pu", pad_pu, VECS[i].pu);
            check("R6 vec", "pad_slew", pad_slew, VECS[i].sl);
        end

        // R4: synchronizer latency of two edges on an input pin
        pin_in = 8'h5A;
        bus_addr = 2'd0;
        settle();
        check("R4", "rdata after 1 edge", bus_rdata, 8'hF5);
        settle();
        check("R4", "rdata after 2 edges", bus_rdata, 8'h55);

        // R7: reset drop releases pin 0 before any clock edge
        rst_n = 1'b0;
        #1;
        check("R7", "pad_oe in reset", pad_oe, 8'h0E);
        check("R7", "pad_out in reset", pad_out, 8'h04);
        settle();
        // R1: registers cleared by the reset edge
        check("R1", "pad_oe after reset", pad_oe, 8'h00);
        rst_n = 1'b1;
        bus_addr = 2'd3;
        #1;
        check("R1", "dir after reset", bus_rdata, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule